// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Register

This block is the serial programming port of a dual-loop frequency synthesizer. A host drives three wires: a serial clock, a data line and an active-low frame strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a 22-bit word, most significant bit first. When the strobe returns high, the last two bits of the word select one of four setting latches. The other 20 bits are written into the selected latch. Two latches hold the reference-divider ratio and mode bits of loop one and loop two. The other two hold the swallow (A) and main (B) counter values of each loop's feedback divider.

The three wires come from outside and are not related to the system clock. They pass through a multi-stage synchronizer and an edge detector, so all logic runs in the `clk` domain. A small state machine tracks the frame. `ST_IDLE` waits with the strobe high and moves to `ST_SHIFT` when the synchronized strobe reads low. `ST_SHIFT` accepts one bit for each serial-clock rise and moves to `ST_LOAD` on a strobe rise. `ST_LOAD` issues a one-cycle commit and always returns to `ST_IDLE`. The latch bank rejects a commit that would set a prohibited divide ratio, and the latch keeps its old value.

Top module: `synth_prog_port`

## Requirements
- R1: Bits enter MSB first. Only the last 22 bits shifted before the strobe rise count. Of these, word[1] is the last-but-one bit and word[0] is the very last bit, and they form the control code. The 20 bits shifted before them form the payload p[19:0], where p[0] is the bit just before the control code.
- R2: Control code word[0]=0 selects a reference latch and word[0]=1 selects a feedback latch. Code word[1]=1 selects loop one and word[1]=0 selects loop two. The four codes {word[1],word[0]} route as follows: 00 goes to the loop-two reference latch, 10 to the loop-one reference latch, 01 to the loop-two feedback latch and 11 to the loop-one feedback latch.
- R3: A reference write sets four fields. The divide ratio is p[14:0], the detector polarity is p[15], the lock-detect select is p[18] and the divider-output select is p[19]. Bits p[16] and p[17] have no effect.
- R4: A feedback write sets the swallow count A from p[6:0] and the main count B from p[17:7]. Bits p[18] and p[19] have no effect.
- R5: Bits are taken only on serial-clock rises while the strobe is low. Serial-clock edges while the strobe is high shift nothing. Latches change only on a strobe rise.
- R6: A reference write whose ratio is below 3 is dropped, and the target latch keeps its previous contents. A ratio of exactly 3 is accepted.
- R7: A feedback write whose B value is below 3 is dropped, and the target latch keeps its previous contents. A B value of exactly 3 is accepted.
- R8: After reset, both reference ratios are 3, both polarities are 1, both selects are 0, both A counts are 0 and both B counts are 3.
- R9: A write changes only the latch its control code selects. The other three latches keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit |
| ser_en_n | input | 1 | Frame strobe, low while shifting |
| rf1_r_div | output | 15 | Loop-one reference divide ratio |
| rf1_pd_pol | output | 1 | Loop-one phase detector polarity |
| rf1_ld_sel | output | 1 | Loop-one lock-detect select |
| rf1_fo_sel | output | 1 | Loop-one divider-output select |
| rf1_a_cnt | output | 7 | Loop-one swallow count |
| rf1_b_cnt | output | 11 | Loop-one main count |
| rf2_r_div | output | 15 | Loop-two reference divide ratio |
| rf2_pd_pol | output | 1 | Loop-two phase detector polarity |
| rf2_ld_sel | output | 1 | Loop-two lock-detect select |
| rf2_fo_sel | output | 1 | Loop-two divider-output select |
| rf2_a_cnt | output | 7 | Loop-two swallow count |
| rf2_b_cnt | output | 11 | Loop-two main count |

## Verification
The assertions assume that each level of the serial wires lasts several system clocks. Under that condition the synchronizer cannot miss a serial-clock edge or merge two of them, and a strobe rise is never seen in the same cycle as a serial-clock rise. The bench holds every serial level for four system clocks and drives all inputs on the falling edge of `clk`. It also leaves thirty clocks between frames, so each commit settles before the next frame begins.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    parameter int R_W     = 15;
    parameter int MODE_W  = 5;
    parameter int A_W     = 7;
    parameter int B_W     = 11;
    parameter int CTRL_W  = 2;
    parameter int PAY_W   = R_W + MODE_W;
    parameter int WORD_W  = PAY_W + CTRL_W;
    parameter int R_MIN   = 3;
    parameter int B_MIN   = 3;
    parameter int LOOPS   = 2;

    // bit positions inside the payload
    parameter int POL_BIT = R_W;
    parameter int LD_BIT  = R_W + 3;
    parameter int FO_BIT  = R_W + 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic [R_W-1:0] ratio;
        logic           pol;
        logic           ld_sel;
        logic           fo_sel;
    } ref_set_t;

    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
    } fb_set_t;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= rst_val;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= rst_val;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= rst_val;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/sp_framer.sv
module sp_framer
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_lvl,
    input  logic              en_n_rise,
    input  logic              sclk_rise,
    input  logic              sdata,
    output frame_state_e      state_o,
    output logic              load_stb,
    output logic [WORD_W-1:0] word_o
);

    frame_state_e state_q, state_d;
    logic         shift_en;
    logic [WORD_W-1:0] sr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!en_n_lvl)  state_d = ST_SHIFT;
            ST_SHIFT: if (en_n_rise)  state_d = ST_LOAD;
            ST_LOAD:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        load_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SHIFT: shift_en = sclk_rise && !en_n_lvl;
            ST_LOAD:  load_stb = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], sdata};
    end

    assign state_o = state_q;
    assign word_o  = sr_q;

endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] word,
    output ref_set_t          ref_q [LOOPS],
    output fb_set_t           fb_q  [LOOPS]
);

    localparam int LSEL_W = $clog2(LOOPS);

    logic [CTRL_W-1:0] ctrl;
    logic [PAY_W-1:0]  pay;
    logic              is_fb;
    logic [LSEL_W-1:0] loop_sel;
    ref_set_t          ref_new;
    fb_set_t           fb_new;
    logic              ref_ok;
    logic              fb_ok;

    assign ctrl     = word[CTRL_W-1:0];
    assign pay      = word[WORD_W-1:CTRL_W];
    assign is_fb    = ctrl[0];
    // control bit 1 high means loop one, stored at index 0
    assign loop_sel = LSEL_W'(!ctrl[1]);

    always_comb begin
        ref_new.ratio  = pay[R_W-1:0];
        ref_new.pol    = pay[POL_BIT];
        ref_new.ld_sel = pay[LD_BIT];
        ref_new.fo_sel = pay[FO_BIT];
        fb_new.a_cnt   = pay[A_W-1:0];
        fb_new.b_cnt   = pay[A_W+B_W-1:A_W];
    end

    assign ref_ok = (ref_new.ratio >= R_W'(R_MIN));
    assign fb_ok  = (fb_new.b_cnt  >= B_W'(B_MIN));

    generate
        for (genvar i = 0; i < LOOPS; i++) begin : g_loop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ref_q[i].ratio  <= R_W'(R_MIN);
                    ref_q[i].pol    <= 1'b1;
                    ref_q[i].ld_sel <= 1'b0;
                    ref_q[i].fo_sel <= 1'b0;
                end else if (load_stb && !is_fb && loop_sel == LSEL_W'(i) && ref_ok) begin
                    ref_q[i] <= ref_new;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fb_q[i].a_cnt <= '0;
                    fb_q[i].b_cnt <= B_W'(B_MIN);
                end else if (load_stb && is_fb && loop_sel == LSEL_W'(i) && fb_ok) begin
                    fb_q[i] <= fb_new;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_en_n,
    output logic [R_W-1:0] rf1_r_div,
    output logic           rf1_pd_pol,
    output logic           rf1_ld_sel,
    output logic           rf1_fo_sel,
    output logic [A_W-1:0] rf1_a_cnt,
    output logic [B_W-1:0] rf1_b_cnt,
    output logic [R_W-1:0] rf2_r_div,
    output logic           rf2_pd_pol,
    output logic           rf2_ld_sel,
    output logic           rf2_fo_sel,
    output logic [A_W-1:0] rf2_a_cnt,
    output logic [B_W-1:0] rf2_b_cnt
);

    localparam int IN_W = 3;

    logic [IN_W-1:0]   in_lvl;
    logic [IN_W-1:0]   in_rise;
    frame_state_e      state;
    logic              load_stb;
    logic [WORD_W-1:0] word;
    ref_set_t          ref_q [LOOPS];
    fb_set_t           fb_q  [LOOPS];

    sp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en_n, ser_data, ser_clk}),
        .rst_val (3'b100),
        .level_o (in_lvl),
        .rise_o  (in_rise)
    );

    sp_framer i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n_lvl  (in_lvl[2]),
        .en_n_rise (in_rise[2]),
        .sclk_rise (in_rise[0]),
        .sdata     (in_lvl[1]),
        .state_o   (state),
        .load_stb  (load_stb),
        .word_o    (word)
    );

    sp_latch_bank i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .word     (word),
        .ref_q    (ref_q),
        .fb_q     (fb_q)
    );

    assign rf1_r_div  = ref_q[0].ratio;
    assign rf1_pd_pol = ref_q[0].pol;
    assign rf1_ld_sel = ref_q[0].ld_sel;
    assign rf1_fo_sel = ref_q[0].fo_sel;
    assign rf1_a_cnt  = fb_q[0].a_cnt;
    assign rf1_b_cnt  = fb_q[0].b_cnt;
    assign rf2_r_div  = ref_q[1].ratio;
    assign rf2_pd_pol = ref_q[1].pol;
    assign rf2_ld_sel = ref_q[1].ld_sel;
    assign rf2_fo_sel = ref_q[1].fo_sel;
    assign rf2_a_cnt  = fb_q[1].a_cnt;
    assign rf2_b_cnt  = fb_q[1].b_cnt;

endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
    import synth_prog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input frame_state_e      state,
    input logic              load_stb,
    input logic [WORD_W-1:0] word,
    input logic [R_W-1:0]    rf1_r_div,
    input logic [R_W-1:0]    rf2_r_div,
    input logic [B_W-1:0]    rf1_b_cnt,
    input logic [B_W-1:0]    rf2_b_cnt,
    input logic [A_W-1:0]    rf1_a_cnt,
    input logic [A_W-1:0]    rf2_a_cnt
);

    // R6
    ref_ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf1_r_div >= R_W'(R_MIN)) && (rf2_r_div >= R_W'(R_MIN)));

    // R7
    fb_b_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf1_b_cnt >= B_W'(B_MIN)) && (rf2_b_cnt >= B_W'(B_MIN)));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable({rf1_r_div, rf2_r_div, rf1_b_cnt, rf2_b_cnt, rf1_a_cnt, rf2_a_cnt}));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |=> $stable(word));

    // R5
    load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

endmodule

bind synth_prog_port synth_prog_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .load_stb  (load_stb),
    .word      (word),
    .rf1_r_div (rf1_r_div),
    .rf2_r_div (rf2_r_div),
    .rf1_b_cnt (rf1_b_cnt),
    .rf2_b_cnt (rf2_b_cnt),
    .rf1_a_cnt (rf1_a_cnt),
    .rf2_a_cnt (rf2_a_cnt)
);

// File: tb/test_synth_prog_port.sv
module test_synth_prog_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_en_n = 1'b1;

    logic [14:0] rf1_r_div, rf2_r_div;
    logic        rf1_pd_pol, rf1_ld_sel, rf1_fo_sel;
    logic        rf2_pd_pol, rf2_ld_sel, rf2_fo_sel;
    logic [6:0]  rf1_a_cnt, rf2_a_cnt;
    logic [10:0] rf1_b_cnt, rf2_b_cnt;

    always #4 clk = ~clk;

    synth_prog_port i_synth_prog_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en_n(ser_en_n),
        .rf1_r_div(rf1_r_div), .rf1_pd_pol(rf1_pd_pol), .rf1_ld_sel(rf1_ld_sel),
        .rf1_fo_sel(rf1_fo_sel), .rf1_a_cnt(rf1_a_cnt), .rf1_b_cnt(rf1_b_cnt),
        .rf2_r_div(rf2_r_div), .rf2_pd_pol(rf2_pd_pol), .rf2_ld_sel(rf2_ld_sel),
        .rf2_fo_sel(rf2_fo_sel), .rf2_a_cnt(rf2_a_cnt), .rf2_b_cnt(rf2_b_cnt)
    );

    // expected snapshot, index 0 = loop one, 1 = loop two
    typedef struct {
        logic [14:0] r   [2];
        logic        pol [2];
        logic        ld  [2];
        logic        fo  [2];
        logic [6:0]  a   [2];
        logic [10:0] b   [2];
        string       tag;
    } snap_t;

    snap_t model;
    snap_t exp_q [$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    finished = 0;

    task automatic chk(input string tag, input string fld, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
        end
    endtask

    task automatic compare(input snap_t e);
        chk(e.tag, "rf1_r_div",  int'(rf1_r_div),  int'(e.r[0]));
        chk(e.tag, "rf1_pd_pol", int'(rf1_pd_pol), int'(e.pol[0]));
        chk(e.tag, "rf1_ld_sel", int'(rf1_ld_sel), int'(e.ld[0]));
        chk(e.tag, "rf1_fo_sel", int'(rf1_fo_sel), int'(e.fo[0]));
        chk(e.tag, "rf1_a_cnt",  int'(rf1_a_cnt),  int'(e.a[0]));
        chk(e.tag, "rf1_b_cnt",  int'(rf1_b_cnt),  int'(e.b[0]));
        chk(e.tag, "rf2_r_div",  int'(rf2_r_div),  int'(e.r[1]));
        chk(e.tag, "rf2_pd_pol", int'(rf2_pd_pol), int'(e.pol[1]));
        chk(e.tag, "rf2_ld_sel", int'(rf2_ld_sel), int'(e.ld[1]));
        chk(e.tag, "rf2_fo_sel", int'(rf2_fo_sel), int'(e.fo[1]));
        chk(e.tag, "rf2_a_cnt",  int'(rf2_a_cnt),  int'(e.a[1]));
        chk(e.tag, "rf2_b_cnt",  int'(rf2_b_cnt),  int'(e.b[1]));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // model update from a 22-bit word (R1..R4, R6, R7, R9)
    task automatic apply(input logic [21:0] w);
        logic [19:0] p;
        int idx;
        p   = w[21:2];
        idx = w[1] ? 0 : 1;
        if (!w[0]) begin
            if (p[14:0] >= 15'd3) begin
                model.r[idx]   = p[14:0];
                model.pol[idx] = p[15];
                model.ld[idx]  = p[18];
                model.fo[idx]  = p[19];
            end
        end else if (p[17:7] >= 11'd3) begin
            model.a[idx] = p[6:0];
            model.b[idx] = p[17:7];
        end
    endtask

    task automatic push(input string tag);
        snap_t s;
        s = model;
        s.tag = tag;
        exp_q.push_back(s);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        @(negedge clk) ser_en_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_en_n = 1'b1;
    endtask

    task automatic send(input logic [21:0] w, input string tag);
        shift_bits({10'd0, w}, 22);
        apply(w);
        push(tag);
        repeat (30) @(negedge clk);
    endtask

    function automatic logic [21:0] mk_ref(input int ratio, input bit pol, input bit ld,
                                           input bit fo, input logic [1:0] spare, input bit loop1);
        return {fo, ld, spare, pol, 15'(ratio), loop1, 1'b0};
    endfunction

    function automatic logic [21:0] mk_fb(input int a, input int b, input logic [1:0] spare,
                                          input bit loop1);
        return {spare, 11'(b), 7'(a), loop1, 1'b1};
    endfunction

    // monitor: compare once the commit has settled
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            repeat (12) @(negedge clk);
            compare(exp_q[0]);
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            model.r[i] = 15'd3; model.pol[i] = 1'b1; model.ld[i] = 1'b0;
            model.fo[i] = 1'b0; model.a[i] = 7'd0;   model.b[i]  = 11'd3;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        push("R8 reset");
        repeat (20) @(negedge clk);

        send(mk_ref(100, 0, 1, 0, 2'b00, 0), "R2 R3 loop2 ref");
        send(mk_ref(32767, 1, 0, 1, 2'b11, 1), "R2 R3 loop1 ref spare ignored");
        send(mk_fb(5, 200, 2'b11, 0), "R2 R4 loop2 fb spare ignored");
        send(mk_fb(127, 2047, 2'b00, 1), "R2 R4 loop1 fb");
        send(mk_ref(2, 0, 1, 1, 2'b00, 1), "R6 ratio 2 dropped");
        send(mk_ref(0, 0, 1, 1, 2'b00, 0), "R6 ratio 0 dropped");
        send(mk_ref(3, 0, 1, 1, 2'b00, 1), "R6 ratio 3 accepted");
        send(mk_fb(9, 2, 2'b00, 0), "R7 b 2 dropped");
        send(mk_fb(9, 3, 2'b00, 0), "R7 b 3 accepted");

        // R5: serial clocks with strobe high, then an empty frame that recommits the held word
        send(mk_ref(777, 1, 1, 0, 2'b00, 0), "R5 setup");
        for (int i = 0; i < 6; i++) begin
            ser_data = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        shift_bits(32'd0, 0);
        push("R5 clocks with strobe high ignored");
        repeat (30) @(negedge clk);

        // R1: long frame, only the last 22 bits count
        begin
            logic [21:0] w;
            w = mk_fb(33, 1500, 2'b00, 1);
            shift_bits({10'h3FF, w}, 26);
            apply(w);
            push("R1 long frame keeps last 22 bits");
            repeat (30) @(negedge clk);
        end

        // R9: mixed writes, untouched latches stay
        for (int i = 0; i < 16; i++) begin
            logic [21:0] w;
            w = 22'($urandom);
            send(w, "R9 R2 mixed write");
        end

        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule